// File: doc/BRIEF.md
# IO Register Write-Conflict Sequencer

This block stands between a processor's register write port and a bank of 128 IO registers that a video unit samples on every T-cycle (one clock). A plain store would change the register in a single cycle. Real hardware instead shows transient values, and commits the new value at offsets that depend on which register is written and which hardware variant is in use. For each accepted write, the block looks up the target's conflict policy. It then replays the write as a timed series of update strobes: an optional one-cycle glitch value, then the final value. When the series ends, it reports how many T-cycles of the processor's bus access remain.

A write request arrives on a valid/ready handshake. It carries the address, the data and a nominal pending-cycle count. Every commit offset is measured from that count. The request fields must be held stable while `req_valid` is high and `req_ready` is low. A request is taken on a clock edge where both are high. `req_ready` stays low until the sequence has finished, which back-pressures any following request. The update outputs have no back-pressure, because the register bank takes every strobe. The bank returns the current content of the addressed register on `reg_cur`. The block uses that value to build the glitch values and the concurrent-read view.

Cycle numbering: the cycle that follows the accepting edge is cycle 1. A strobe "at cycle k" is high during cycle k, and the bank stores its value on the edge that ends cycle k. P is the effective pending count.

Top module: `io_write_conflict_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is running. It falls on the accepting edge and rises again on the edge that ends the final-commit cycle, so a request held during a sequence is taken one cycle after `done`.
- R2: The policy is selected by the 7-bit address together with `mode` (0 = first variant, 1 = second). Address 0x0F (interrupt flags) and 0x45 (line compare) use write-wins in both variants. Addresses 0x47, 0x48 and 0x49 (palettes) use OR-palette in mode 0 and early-palette in mode 1. Address 0x41 (status) uses status-glitch in mode 0 and plain in mode 1. Address 0x4A uses read-new, 0x4B uses read-old, and every other address uses plain.
- R3: Plain, read-old and read-new each commit the new value once, at cycle P, with remain = 4.
- R4: Write-wins commits the new value once, at cycle P+1, with remain = 3.
- R5: OR-palette writes (current value OR new value) at cycle P-2, then the new value at cycle P-1, with remain = 5.
- R6: Early-palette commits the new value once, at cycle P-2, with no glitch, and remain = 6.
- R7: Status-glitch writes 0xFF at cycle P, then the new value at cycle P+1, with remain = 3.
- R8: If `disp_state` is 7 and (`reg_cur` AND 0x28) equals 0x08 in the glitch cycle, the status glitch value is 0xDF instead of 0xFF.
- R9: A pending count below 3 is treated as 3.
- R10: `done` is high for exactly the final-commit cycle, together with `upd_we`. `remain` carries the count in that cycle and is 0 in every other cycle. `upd_addr` holds the target address for the whole sequence.
- R11: `peek_data` (what a concurrent reader of `upd_addr` sees) shows the new value during the commit cycle of a read-new write. In every other case it shows `reg_cur`.
- R12: Reset leaves the block idle: `req_ready` is 1, and `upd_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Hardware variant select |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 7 | Register index |
| req_data | input | 8 | Value written by the processor |
| req_pending | input | 4 | Nominal pending-cycle count |
| disp_state | input | 3 | Display state from the video unit |
| reg_cur | input | 8 | Current content of register `upd_addr` |
| upd_we | output | 1 | Register update strobe |
| upd_addr | output | 7 | Register being updated |
| upd_data | output | 8 | Value to store |
| done | output | 1 | Final commit of the sequence |
| remain | output | 3 | Remaining T-cycles of the access, valid with `done` |
| peek_data | output | 8 | Value a same-cycle reader of `upd_addr` sees |

## Verification
The hardest case to reach is the display-state-7 exception. It needs mode 0, a write to the status register, and both conditions true in the single glitch cycle: `disp_state` at 7 and a stored status value whose bits 0x28 read 0x08. The bench preloads its model register bank with such a value and holds `disp_state` for the whole sequence. It then adds neighbouring vectors where only one of the two conditions holds, to show that the glitch value goes back to 0xFF. A second hard case is back-pressure: a request raised in the middle of a sequence must wait until the cycle after `done`.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;
  localparam int REM_W  = 3;
  localparam int DISP_W = 3;

  // register indices whose behaviour differs
  localparam logic [IDX_W-1:0] IX_IRQ  = 7'h0F;
  localparam logic [IDX_W-1:0] IX_STAT = 7'h41;
  localparam logic [IDX_W-1:0] IX_LCMP = 7'h45;
  localparam logic [IDX_W-1:0] IX_PALA = 7'h47;
  localparam logic [IDX_W-1:0] IX_PALB = 7'h48;
  localparam logic [IDX_W-1:0] IX_PALC = 7'h49;
  localparam logic [IDX_W-1:0] IX_WINY = 7'h4A;
  localparam logic [IDX_W-1:0] IX_WINX = 7'h4B;

  localparam logic [BYTE_W-1:0] GLITCH_ALL  = 8'hFF;
  localparam logic [BYTE_W-1:0] GLITCH_EDGE = 8'hDF;
  localparam logic [BYTE_W-1:0] STAT_MASK   = 8'h28;
  localparam logic [BYTE_W-1:0] STAT_MATCH  = 8'h08;
  localparam logic [DISP_W-1:0] EDGE_STATE  = 3'd7;

  typedef enum logic [2:0] {
    POL_PLAIN,
    POL_READ_OLD,
    POL_READ_NEW,
    POL_WRITE_WINS,
    POL_PAL_OR,
    POL_PAL_EARLY,
    POL_STAT_GLITCH
  } policy_e;

  function automatic policy_e policy_of(input logic variant, input logic [IDX_W-1:0] idx);
    policy_e p;
    case (idx)
      IX_IRQ, IX_LCMP:        p = POL_WRITE_WINS;
      IX_STAT:                p = variant ? POL_PLAIN : POL_STAT_GLITCH;
      IX_PALA, IX_PALB, IX_PALC: p = variant ? POL_PAL_EARLY : POL_PAL_OR;
      IX_WINY:                p = POL_READ_NEW;
      IX_WINX:                p = POL_READ_OLD;
      default:                p = POL_PLAIN;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/wcs_policy_map.sv
module wcs_policy_map
  import wcs_pkg::*;
#(
  parameter int VARIANTS = 2
) (
  input  logic             mode,
  input  logic [IDX_W-1:0] idx,
  output policy_e          pol
);
  localparam int DEPTH = 1 << IDX_W;

  policy_e tbl [VARIANTS][DEPTH];

  for (genvar v = 0; v < VARIANTS; v++) begin : g_var
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[v][i] = policy_of(1'(v), IDX_W'(i));
    end
  end

  assign pol = tbl[mode][idx];

endmodule

// File: rtl/wcs_schedule.sv
module wcs_schedule
  import wcs_pkg::*;
#(
  parameter int PEND_W = 4,
  parameter int MIN_P  = 3
) (
  input  policy_e             pol,
  input  logic [PEND_W-1:0]   pending,
  output logic                has_glitch,
  output logic [PEND_W:0]     glitch_at,
  output logic [PEND_W:0]     final_at,
  output logic [REM_W-1:0]    rem
);
  localparam int CNT_W = PEND_W + 1;

  logic [CNT_W-1:0] p;

  always_comb begin
    p = (pending < PEND_W'(MIN_P)) ? CNT_W'(MIN_P) : CNT_W'(pending);
    has_glitch = 1'b0;
    glitch_at  = '0;
    final_at   = p;
    rem        = REM_W'(4);
    case (pol)
      POL_WRITE_WINS: begin
        final_at = p + CNT_W'(1);
        rem      = REM_W'(3);
      end
      POL_PAL_OR: begin
        has_glitch = 1'b1;
        glitch_at  = p - CNT_W'(2);
        final_at   = p - CNT_W'(1);
        rem        = REM_W'(5);
      end
      POL_PAL_EARLY: begin
        final_at = p - CNT_W'(2);
        rem      = REM_W'(6);
      end
      POL_STAT_GLITCH: begin
        has_glitch = 1'b1;
        glitch_at  = p;
        final_at   = p + CNT_W'(1);
        rem        = REM_W'(3);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wcs_glitch.sv
module wcs_glitch
  import wcs_pkg::*;
(
  input  policy_e            pol,
  input  logic [BYTE_W-1:0]  cur,
  input  logic [BYTE_W-1:0]  newv,
  input  logic [DISP_W-1:0]  disp_state,
  output logic [BYTE_W-1:0]  gval
);
  logic edge_case;

  assign edge_case = (disp_state == EDGE_STATE) && ((cur & STAT_MASK) == STAT_MATCH);

  always_comb begin
    case (pol)
      POL_PAL_OR:      gval = cur | newv;
      POL_STAT_GLITCH: gval = edge_case ? GLITCH_EDGE : GLITCH_ALL;
      default:         gval = newv;
    endcase
  end

endmodule

// File: rtl/io_write_conflict_seq.sv
module io_write_conflict_seq
  import wcs_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_addr,
  input  logic [BYTE_W-1:0]  req_data,
  input  logic [PEND_W-1:0]  req_pending,
  input  logic [DISP_W-1:0]  disp_state,
  input  logic [BYTE_W-1:0]  reg_cur,
  output logic               upd_we,
  output logic [IDX_W-1:0]   upd_addr,
  output logic [BYTE_W-1:0]  upd_data,
  output logic               done,
  output logic [REM_W-1:0]   remain,
  output logic [BYTE_W-1:0]  peek_data
);
  localparam int CNT_W = PEND_W + 1;

  policy_e          pol_lk;
  logic             hasg_lk;
  logic [CNT_W-1:0] gat_lk, fat_lk;
  logic [REM_W-1:0] rem_lk;

  wcs_policy_map #(.VARIANTS(2)) u_map (
    .mode(mode), .idx(req_addr), .pol(pol_lk)
  );

  wcs_schedule #(.PEND_W(PEND_W), .MIN_P(3)) u_sched (
    .pol(pol_lk), .pending(req_pending), .has_glitch(hasg_lk),
    .glitch_at(gat_lk), .final_at(fat_lk), .rem(rem_lk)
  );

  logic             busy;
  logic [CNT_W-1:0] cnt, gat_q, fat_q;
  logic             hasg_q;
  logic [REM_W-1:0] rem_q;
  policy_e          pol_q;
  logic [BYTE_W-1:0] new_q;
  logic [IDX_W-1:0]  addr_q;
  logic [BYTE_W-1:0] gval;

  wcs_glitch u_glitch (
    .pol(pol_q), .cur(reg_cur), .newv(new_q), .disp_state(disp_state), .gval(gval)
  );

  logic accept, glitch_hit, final_hit;

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign glitch_hit = busy && hasg_q && (cnt == gat_q);
  assign final_hit  = busy && (cnt == fat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      gat_q  <= '0;
      fat_q  <= '0;
      hasg_q <= 1'b0;
      rem_q  <= '0;
      pol_q  <= POL_PLAIN;
      new_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(1);
      gat_q  <= gat_lk;
      fat_q  <= fat_lk;
      hasg_q <= hasg_lk;
      rem_q  <= rem_lk;
      pol_q  <= pol_lk;
      new_q  <= req_data;
      addr_q <= req_addr;
    end else if (busy) begin
      if (final_hit) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign upd_we    = glitch_hit || final_hit;
  assign upd_addr  = addr_q;
  assign upd_data  = final_hit ? new_q : gval;
  assign done      = final_hit;
  assign remain    = final_hit ? rem_q : '0;
  assign peek_data = (final_hit && pol_q == POL_READ_NEW) ? new_q : reg_cur;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(upd_addr)); // R10
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_GLITCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && !done) |=> (upd_we && done)); // R5
  AST_REMAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remain >= REM_W'(3) && remain <= REM_W'(6))); // R10
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !req_ready); // R1
  AST_READY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!upd_we && remain == '0)); // R10

endmodule

// File: tb/sim_io_write_conflict_seq.sv
module sim_io_write_conflict_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [6:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [3:0] req_pending = '0;
  logic [2:0] disp_state = '0;
  logic [7:0] reg_cur;
  logic upd_we, done;
  logic [6:0] upd_addr;
  logic [7:0] upd_data, peek_data;
  logic [2:0] remain;

  always #4 clk = ~clk; // 125 MHz

  io_write_conflict_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_pending(req_pending),
    .disp_state(disp_state), .reg_cur(reg_cur), .upd_we(upd_we), .upd_addr(upd_addr),
    .upd_data(upd_data), .done(done), .remain(remain), .peek_data(peek_data)
  );

  // bench-side register bank
  logic [7:0] bank [128];
  logic       pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [7:0] pre_val = '0;
  assign reg_cur = bank[upd_addr];
  always @(posedge clk) begin
    if (upd_we) bank[upd_addr] <= upd_data;
    else if (pre_we) bank[pre_addr] <= pre_val;
  end

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // {mode, addr, data, pend, init, disp, glitch_k, final_k, rem, gval, peek_new}
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 7'h47, 8'h1C, 4'd5, 8'hE1, 3'd0, 5'd3, 5'd4, 3'd5, 8'hFD, 1'b0}, // R5
    {1'b1, 7'h47, 8'h1C, 4'd5, 8'hE1, 3'd0, 5'd0, 5'd3, 3'd6, 8'h00, 1'b0}, // R6
    {1'b0, 7'h41, 8'h40, 4'd4, 8'h08, 3'd7, 5'd4, 5'd5, 3'd3, 8'hDF, 1'b0}, // R8
    {1'b0, 7'h41, 8'h40, 4'd4, 8'h08, 3'd6, 5'd4, 5'd5, 3'd3, 8'hFF, 1'b0}, // R7
    {1'b0, 7'h41, 8'h40, 4'd4, 8'h28, 3'd7, 5'd4, 5'd5, 3'd3, 8'hFF, 1'b0}, // R8
    {1'b1, 7'h0F, 8'h05, 4'd4, 8'h00, 3'd0, 5'd0, 5'd5, 3'd3, 8'h00, 1'b0}, // R4
    {1'b0, 7'h10, 8'hAA, 4'd4, 8'h55, 3'd0, 5'd0, 5'd4, 3'd4, 8'h00, 1'b0}, // R3
    {1'b1, 7'h41, 8'h3C, 4'd4, 8'h01, 3'd7, 5'd0, 5'd4, 3'd4, 8'h00, 1'b0}, // R2
    {1'b0, 7'h49, 8'h30, 4'd1, 8'h03, 3'd0, 5'd1, 5'd2, 3'd5, 8'h33, 1'b0}, // R9
    {1'b1, 7'h45, 8'h99, 4'd6, 8'h11, 3'd0, 5'd0, 5'd7, 3'd3, 8'h00, 1'b0}, // R4
    {1'b0, 7'h4A, 8'h77, 4'd3, 8'h12, 3'd0, 5'd0, 5'd3, 3'd4, 8'h00, 1'b1}, // R11
    {1'b0, 7'h4B, 8'h66, 4'd4, 8'h21, 3'd0, 5'd0, 5'd4, 3'd4, 8'h00, 1'b0}  // R11
  };

  task automatic preload(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_val = v;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", 16'(req_ready), 16'd1);
    chk("R12 upd_we in reset", 16'(upd_we), 16'd0);
    chk("R12 done in reset", 16'(done), 16'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [52:0] e;
      logic [7:0] init_v, data_v, gval_v, bank_exp;
      logic [4:0] gk, fk;
      logic [6:0] a;
      e = VEC[v];
      a = e[51:45]; data_v = e[44:37]; init_v = e[32:25];
      gk = e[21:17]; fk = e[16:12]; gval_v = e[8:1];
      preload(a, init_v);
      mode = e[52]; req_addr = a; req_data = data_v; req_pending = e[36:33];
      disp_state = e[24:22]; req_valid = 1'b1;
      chk("R1 ready before request", 16'(req_ready), 16'd1);
      @(posedge clk);
      bank_exp = init_v;
      for (int k = 1; k <= 31; k++) begin
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 32'(gk) && gk != 0) begin
          chk("R5 R7 glitch strobe", 16'(upd_we), 16'd1);
          chk("R5 R7 R8 glitch value", 16'(upd_data), 16'(gval_v));
          chk("R10 no done on glitch", 16'(done), 16'd0);
          bank_exp = gval_v;
        end else if (k == 32'(fk)) begin
          chk("R3 R4 R6 final strobe", 16'(upd_we), 16'd1);
          chk("R3 R4 R6 final value", 16'(upd_data), 16'(data_v));
          chk("R10 done", 16'(done), 16'd1);
          chk("R10 remain", 16'(remain), 16'(e[11:9]));
          chk("R10 target addr", 16'(upd_addr), 16'(a));
          chk("R1 ready low at done", 16'(req_ready), 16'd0);
          chk("R11 peek", 16'(peek_data), 16'(e[0] ? data_v : bank_exp));
          break;
        end else begin
          chk("R2 no strobe off schedule", 16'(upd_we), 16'd0);
        end
      end
      @(negedge clk);
      chk("R1 ready after sequence", 16'(req_ready), 16'd1);
      chk("R10 done cleared", 16'(done), 16'd0);
      chk("R3 stored value", 16'(bank[a]), 16'(data_v));
    end

    // back-pressure: request B raised while A runs
    preload(7'h12, 8'h00);
    mode = 1'b0; req_addr = 7'h10; req_data = 8'h11; req_pending = 4'd3; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 7'h12; req_data = 8'h22; req_pending = 4'd3; req_valid = 1'b1;
    chk("R1 ready low while busy", 16'(req_ready), 16'd0);
    @(negedge clk);
    chk("R1 ready low cycle 2", 16'(req_ready), 16'd0);
    @(negedge clk);
    chk("R1 A done", 16'(done), 16'd1);
    chk("R1 A target", 16'(upd_addr), 16'h10);
    @(negedge clk);
    chk("R1 ready after A", 16'(req_ready), 16'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 B accepted", 16'(req_ready), 16'd0);
    repeat (3) @(negedge clk);
    chk("R1 B stored", 16'(bank[7'h12]), 16'h22);
    chk("R1 A stored", 16'(bank[7'h10]), 16'h11);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule